// File: doc/BRIEF.md
# Multi-Rail Sleep-State Power Sequencer

This block walks a host platform through four stable power levels: off, soft-off, suspend-to-RAM and fully-on. Every move between two levels goes through its own transition sequence. In that sequence the block switches supply rails on or off in a fixed order, waits fixed settle times and watches rail power-good inputs and the chipset's active-low sleep lines. When a rail never reports good within its timeout, the block forces a shutdown by dropping the deep-well power-good. It then backs off to the lower level.

All delays come from one restartable timer. A prescaler in that timer turns clock cycles into millisecond ticks, so a single clock-rate parameter scales every wait. All asynchronous inputs pass through synchronizer flops first. A power-on request starts bring-up from off. A throttle request is passed to the CPU throttle line only while the platform is fully on. A pause input makes the shutdown path stop in soft-off instead of continuing to off.

Top module: `pwr_sleep_seq`

## Requirements
- R1: While reset is held and just after it, every rail enable, every power-good output, the throttle line, the touchpad enable and both active-low reset outputs are 0, and the radio state reads off.
- R2: A power-on request in the off level turns on the deep-well 3.3 V enable first. The 5 V enable follows `DW_SETTLE_MS` later. Once the 1.05 V and 1.2 V goods both read low, the gated deep-well enable, the deep-well power-good and the 1.05 V enable turn on together.
- R3: If the 1.05 V and 1.2 V goods do not both fall within `V5_TMO_MS`, the 5 V enable and the deep-well power-good go low and the block returns to off without enabling the gated rail.
- R4: If the 1.05 V good and a high suspend-well sleep line are not both seen within `PG_TMO_MS`, the 1.05 V, gated deep-well and 5 V enables and the deep-well power-good all go low, and the block returns to off.
- R5: In soft-off, a high soft-off sleep line turns on the 1.8 V and 1.2 V enables. When both goods are seen, the light-bar reset is released and the touchpad and USB 5 V enables turn on, which marks the suspend level.
- R6: If the two memory goods are not both seen within `PG_TMO_MS`, both memory enables and the deep-well power-good go low and the block stays in soft-off.
- R7: In suspend, the loss of either memory good takes precedence over a high suspend sleep line. The block forces shutdown and goes down, and the radio never reaches the on code.
- R8: A high suspend sleep line in suspend sets the radio to on and releases the touchscreen reset after `RESUME_DLY_MS`. After the 1.05 V good is seen and a further `PWROK_DLY_MS` has passed, the chipset and system power-goods rise.
- R9: In the on level, a low suspend sleep line or the loss of the 1.05 V good starts the way down. The system power-good falls exactly one cycle before the chipset power-good. After at least `GAP_CYC` further cycles the radio reads suspend and the throttle line is 0. Loss of the 1.05 V good also drops the deep-well power-good.
- R10: The throttle line changes only as the block enters, stays in or leaves the on level. Throttle requests in any other level have no effect on it.
- R11: A low soft-off sleep line in suspend turns off the radio, the touchpad, USB 5 V and both memory enables, and puts the touchscreen and light bar into reset. With pause set, the block stops in soft-off with the deep-well power-good still high. Without pause, the deep-well power-good falls one cycle before the 1.05 V, gated, 5 V and deep-well 3.3 V enables turn off.
- R12: The radio state uses 2'b00 for off, 2'b01 for suspend and 2'b10 for on, and never reads 2'b11.
- R13: The system power-good implies the chipset power-good. The chipset power-good implies the 1.05 V, 1.8 V and 1.2 V enables. The deep-well power-good implies the gated deep-well enable. The 1.8 V enable implies the 5 V enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_req | input | 1 | Request to leave the off level |
| pause_soft_off | input | 1 | Stop in soft-off on the way down |
| throttle_req | input | 1 | Requested CPU throttle level |
| pg_v1p05 | input | 1 | 1.05 V rail power-good |
| pg_v1p2 | input | 1 | 1.2 V memory rail power-good |
| pg_v1p8 | input | 1 | 1.8 V memory rail power-good |
| sleep_aux_n | input | 1 | Suspend-well sleep line, active low |
| sleep_ram_n | input | 1 | Suspend-to-RAM sleep line, active low |
| sleep_soft_n | input | 1 | Soft-off sleep line, active low |
| en_dw3v3 | output | 1 | Deep-well 3.3 V rail enable |
| en_5v0 | output | 1 | 5 V rail enable |
| en_dw_gated | output | 1 | Gated deep-well rail enable |
| en_v1p05 | output | 1 | 1.05 V rail enable |
| en_v1p2 | output | 1 | 1.2 V memory rail enable |
| en_v1p8 | output | 1 | 1.8 V memory rail enable |
| en_usb_5v0 | output | 1 | USB 5 V enable |
| deep_well_ok | output | 1 | Deep-well power-good to the chipset |
| chip_pwr_ok | output | 1 | Chipset power-good |
| sys_pwr_ok | output | 1 | System power-good |
| cpu_throttle | output | 1 | CPU throttle line |
| lightbar_rst_n | output | 1 | Light-bar reset, active low |
| touchpad_en | output | 1 | Touchpad power enable |
| touchscreen_rst_n | output | 1 | Touchscreen reset, active low |
| radio_state | output | 2 | Wireless state code |

## Verification
The bench goes after the cases where a condition has to win against another or an order has to hold. A rail lost in suspend at the same moment the suspend line rises must win over the resume. If it did not, the radio would briefly read on. The down sequences are timed cycle by cycle: if the power-goods dropped in the same cycle, or the deep-well power-good stayed up while the rails went off, the one-cycle spacing check would report it. Each timeout path is driven into: the 5 V path, the 1.05 V path and the memory path. A design that waited forever would leave rails enabled, and one that cleaned up the wrong rails would be caught by the enable checks. Random throttle requests are applied both in the on level and in suspend, so a throttle line left ungated would follow the request outside the on level.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [1:0] {
      WL_OFF     = 2'b00,
      WL_SUSPEND = 2'b01,
      WL_ON      = 2'b10
   } wl_state_t;

   typedef enum logic [4:0] {
      S_OFF,
      S_UP_DW,
      S_UP_5V,
      S_UP_CORE,
      S_UP_AUXCLK,
      S_SOFT,
      S_UP_MEM,
      S_SUSP,
      S_UP_RESUME,
      S_UP_CORE_PG,
      S_UP_PWROK,
      S_ON,
      S_DN_SYS,
      S_DN_CHIP,
      S_DN_GAP,
      S_DN_SOFT,
      S_DN_OFF
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (WIDTH >= 1) else $error("pwrseq_sync: WIDTH must be at least 1");
      assert (STAGES >= 0) else $error("pwrseq_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0][WIDTH-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
   parameter int TICK_DIV = 100000,
   parameter int MS_W     = 11,
   parameter int GAP_CYC  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   output logic [MS_W-1:0] ms_cnt,
   output logic            gap_done
);

   localparam int              PRE_W    = $clog2(TICK_DIV);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
   localparam logic [MS_W-1:0]  MS_MAX   = '1;

   initial begin
      assert (TICK_DIV >= 2) else $error("pwrseq_ms_timer: TICK_DIV must be at least 2");
      assert (GAP_CYC < TICK_DIV) else $error("pwrseq_ms_timer: GAP_CYC must be below TICK_DIV");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         ms_cnt <= '0;
      end else if (clear) begin
         pre_q  <= '0;
         ms_cnt <= '0;
      end else if (pre_q == PRE_LAST) begin
         pre_q <= '0;
         if (ms_cnt != MS_MAX) ms_cnt <= ms_cnt + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign gap_done = (ms_cnt != '0) || (pre_q >= PRE_W'(GAP_CYC));

   // R2
   ms_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_cnt == MS_MAX && !clear) |=> (ms_cnt == MS_MAX));

   // R9
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ms_cnt == '0 && !gap_done));

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq #(
   parameter int TICK_DIV      = 100000,
   parameter int DW_SETTLE_MS  = 10,
   parameter int V5_TMO_MS     = 1000,
   parameter int PG_TMO_MS     = 100,
   parameter int AUXCLK_MS     = 5,
   parameter int RESUME_DLY_MS = 20,
   parameter int PWROK_DLY_MS  = 99,
   parameter int GAP_CYC       = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       power_req,
   input  logic       pause_soft_off,
   input  logic       throttle_req,
   input  logic       pg_v1p05,
   input  logic       pg_v1p2,
   input  logic       pg_v1p8,
   input  logic       sleep_aux_n,
   input  logic       sleep_ram_n,
   input  logic       sleep_soft_n,
   output logic       en_dw3v3,
   output logic       en_5v0,
   output logic       en_dw_gated,
   output logic       en_v1p05,
   output logic       en_v1p2,
   output logic       en_v1p8,
   output logic       en_usb_5v0,
   output logic       deep_well_ok,
   output logic       chip_pwr_ok,
   output logic       sys_pwr_ok,
   output logic       cpu_throttle,
   output logic       lightbar_rst_n,
   output logic       touchpad_en,
   output logic       touchscreen_rst_n,
   output logic [1:0] radio_state
);
   import pwrseq_pkg::*;

   localparam int MAX_MS = max2(max2(max2(DW_SETTLE_MS, V5_TMO_MS), max2(PG_TMO_MS, AUXCLK_MS)),
                                max2(RESUME_DLY_MS, PWROK_DLY_MS));
   localparam int MS_W   = $clog2(MAX_MS + 1) + 1;
   localparam int NIN    = 9;

   initial begin
      assert (MAX_MS >= 1) else $error("pwr_sleep_seq: delays must not all be zero");
   end

   // input synchronizers
   logic [NIN-1:0] in_raw, in_s;
   assign in_raw = {pause_soft_off, throttle_req, power_req, sleep_soft_n,
                    sleep_ram_n, sleep_aux_n, pg_v1p8, pg_v1p2, pg_v1p05};

   pwrseq_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(in_raw), .q(in_s));

   logic s_pg105, s_pg12, s_pg18, s_aux, s_ram, s_soft, s_req, s_thr, s_pause;
   assign {s_pause, s_thr, s_req, s_soft, s_ram, s_aux, s_pg18, s_pg12, s_pg105} = in_s;

   // timer
   seq_state_t      state, st_nxt;
   logic [MS_W-1:0] ms_cnt;
   logic            gap_done;
   logic            mem_good;

   pwrseq_ms_timer #(.TICK_DIV(TICK_DIV), .MS_W(MS_W), .GAP_CYC(GAP_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(st_nxt != state),
      .ms_cnt(ms_cnt), .gap_done(gap_done));

   function automatic logic ms_at(input logic [MS_W-1:0] cnt, input int lim);
      return cnt >= MS_W'(lim);
   endfunction

   assign mem_good = s_pg18 && s_pg12;

   always_comb begin
      st_nxt = state;
      unique case (state)
         S_OFF:        if (s_req) st_nxt = S_UP_DW;
         S_UP_DW:      if (ms_at(ms_cnt, DW_SETTLE_MS)) st_nxt = S_UP_5V;
         S_UP_5V:      if (!s_pg105 && !s_pg12) st_nxt = S_UP_CORE;
                       else if (ms_at(ms_cnt, V5_TMO_MS)) st_nxt = S_OFF;
         S_UP_CORE:    if (s_pg105 && s_aux) st_nxt = S_UP_AUXCLK;
                       else if (ms_at(ms_cnt, PG_TMO_MS)) st_nxt = S_OFF;
         S_UP_AUXCLK:  if (ms_at(ms_cnt, AUXCLK_MS)) st_nxt = S_SOFT;
         S_SOFT:       if (s_soft) st_nxt = S_UP_MEM;
         S_UP_MEM:     if (mem_good) st_nxt = S_SUSP;
                       else if (ms_at(ms_cnt, PG_TMO_MS)) st_nxt = S_SOFT;
         S_SUSP:       if (!mem_good) st_nxt = S_DN_SOFT;
                       else if (s_ram) st_nxt = S_UP_RESUME;
                       else if (!s_soft) st_nxt = S_DN_SOFT;
         S_UP_RESUME:  if (ms_at(ms_cnt, RESUME_DLY_MS)) st_nxt = S_UP_CORE_PG;
         S_UP_CORE_PG: if (s_pg105) st_nxt = S_UP_PWROK;
                       else if (ms_at(ms_cnt, PG_TMO_MS)) st_nxt = S_SUSP;
         S_UP_PWROK:   if (ms_at(ms_cnt, PWROK_DLY_MS)) st_nxt = S_ON;
         S_ON:         if (!s_pg105 || !s_ram) st_nxt = S_DN_SYS;
         S_DN_SYS:     st_nxt = S_DN_CHIP;
         S_DN_CHIP:    st_nxt = S_DN_GAP;
         S_DN_GAP:     if (gap_done) st_nxt = S_SUSP;
         S_DN_SOFT:    st_nxt = s_pause ? S_SOFT : S_DN_OFF;
         S_DN_OFF:     st_nxt = S_OFF;
         default:      st_nxt = S_OFF;
      endcase
   end

   wl_state_t radio_q;
   assign radio_state = radio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state             <= S_OFF;
         en_dw3v3          <= 1'b0;
         en_5v0            <= 1'b0;
         en_dw_gated       <= 1'b0;
         en_v1p05          <= 1'b0;
         en_v1p2           <= 1'b0;
         en_v1p8           <= 1'b0;
         en_usb_5v0        <= 1'b0;
         deep_well_ok      <= 1'b0;
         chip_pwr_ok       <= 1'b0;
         sys_pwr_ok        <= 1'b0;
         cpu_throttle      <= 1'b0;
         lightbar_rst_n    <= 1'b0;
         touchpad_en       <= 1'b0;
         touchscreen_rst_n <= 1'b0;
         radio_q           <= WL_OFF;
      end else begin
         state <= st_nxt;
         unique case (state)
            S_OFF: if (st_nxt == S_UP_DW) en_dw3v3 <= 1'b1;
            S_UP_DW: if (st_nxt == S_UP_5V) en_5v0 <= 1'b1;
            S_UP_5V:
               if (st_nxt == S_UP_CORE) begin
                  en_dw_gated  <= 1'b1;
                  deep_well_ok <= 1'b1;
                  en_v1p05     <= 1'b1;
               end else if (st_nxt == S_OFF) begin
                  en_5v0       <= 1'b0;
                  deep_well_ok <= 1'b0;
               end
            S_UP_CORE:
               if (st_nxt == S_OFF) begin
                  en_v1p05     <= 1'b0;
                  en_dw_gated  <= 1'b0;
                  en_5v0       <= 1'b0;
                  deep_well_ok <= 1'b0;
               end
            S_SOFT:
               if (st_nxt == S_UP_MEM) begin
                  en_v1p8 <= 1'b1;
                  en_v1p2 <= 1'b1;
               end
            S_UP_MEM:
               if (st_nxt == S_SUSP) begin
                  lightbar_rst_n <= 1'b1;
                  touchpad_en    <= 1'b1;
                  en_usb_5v0     <= 1'b1;
               end else if (st_nxt == S_SOFT) begin
                  en_v1p8      <= 1'b0;
                  en_v1p2      <= 1'b0;
                  deep_well_ok <= 1'b0;
               end
            S_SUSP: if (!mem_good) deep_well_ok <= 1'b0;
            S_UP_RESUME:
               if (st_nxt == S_UP_CORE_PG) begin
                  radio_q           <= WL_ON;
                  touchscreen_rst_n <= 1'b1;
               end
            S_UP_CORE_PG:
               if (st_nxt == S_SUSP) begin
                  deep_well_ok <= 1'b0;
                  radio_q      <= WL_OFF;
               end
            S_UP_PWROK:
               if (st_nxt == S_ON) begin
                  cpu_throttle <= s_thr;
                  chip_pwr_ok  <= 1'b1;
                  sys_pwr_ok   <= 1'b1;
               end
            S_ON: begin
               cpu_throttle <= s_thr;
               if (st_nxt == S_DN_SYS) begin
                  sys_pwr_ok <= 1'b0;
                  if (!s_pg105) deep_well_ok <= 1'b0;
               end
            end
            S_DN_SYS: chip_pwr_ok <= 1'b0;
            S_DN_CHIP: ;
            S_DN_GAP:
               if (st_nxt == S_SUSP) begin
                  radio_q      <= WL_SUSPEND;
                  cpu_throttle <= 1'b0;
               end
            S_DN_SOFT: begin
               radio_q           <= WL_OFF;
               touchpad_en       <= 1'b0;
               en_usb_5v0        <= 1'b0;
               en_v1p8           <= 1'b0;
               en_v1p2           <= 1'b0;
               touchscreen_rst_n <= 1'b0;
               lightbar_rst_n    <= 1'b0;
               if (!s_pause) deep_well_ok <= 1'b0;
            end
            S_DN_OFF: begin
               en_v1p05    <= 1'b0;
               en_dw_gated <= 1'b0;
               en_5v0      <= 1'b0;
               en_dw3v3    <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // R13
   pwrok_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_pwr_ok |-> chip_pwr_ok);

   // R13
   on_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_pwr_ok |-> (en_v1p05 && en_v1p8 && en_v1p2));

   // R13
   dw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deep_well_ok |-> en_dw_gated);

   // R13
   mem_needs_5v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_v1p8 |-> en_5v0);

   // R2
   up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_5v0) |-> en_dw3v3);

   // R9
   pok_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_pwr_ok) |=> $fell(chip_pwr_ok));

   // R10
   throttle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_throttle) |-> ($past(state) == S_UP_PWROK || $past(state) == S_ON ||
                                  $past(state) == S_DN_GAP));

   // R12
   wl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      radio_state != 2'b11);

endmodule

// File: tb/sim_pwr_sleep_seq.sv
module sim_pwr_sleep_seq;

   localparam int TDIV    = 10;
   localparam int DW_MS   = 2;
   localparam int V5_MS   = 6;
   localparam int PG_MS   = 4;
   localparam int AUX_MS  = 1;
   localparam int RES_MS  = 2;
   localparam int POK_MS  = 3;
   localparam int GAP     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic power_req = 0, pause_soft_off = 0, throttle_req = 0;
   logic pg_v1p05 = 0, pg_v1p2 = 0, pg_v1p8 = 0;
   logic sleep_aux_n = 0, sleep_ram_n = 0, sleep_soft_n = 0;
   logic en_dw3v3, en_5v0, en_dw_gated, en_v1p05, en_v1p2, en_v1p8, en_usb_5v0;
   logic deep_well_ok, chip_pwr_ok, sys_pwr_ok, cpu_throttle;
   logic lightbar_rst_n, touchpad_en, touchscreen_rst_n;
   logic [1:0] radio_state;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   pwr_sleep_seq #(
      .TICK_DIV(TDIV), .DW_SETTLE_MS(DW_MS), .V5_TMO_MS(V5_MS), .PG_TMO_MS(PG_MS),
      .AUXCLK_MS(AUX_MS), .RESUME_DLY_MS(RES_MS), .PWROK_DLY_MS(POK_MS),
      .GAP_CYC(GAP), .SYNC_STAGES(2)
   ) u0 (.*);

   // expected radio codes, from R12
   function automatic int radio_code(input string lvl);
      if (lvl == "on") return 2;
      if (lvl == "suspend") return 1;
      return 0;
   endfunction

   // cycles to cover a millisecond wait plus synchronizer and register slack
   function automatic int wait_cyc(input int ms, input int slack);
      return ms * TDIV + slack;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bring_up();
      pg_v1p05 = 0; pg_v1p2 = 0; pg_v1p8 = 0;
      sleep_aux_n = 0; sleep_ram_n = 0; sleep_soft_n = 0;
      power_req = 1; cyc(2); power_req = 0;
      cyc(wait_cyc(DW_MS, 8));
      chk("R2 1.05V enable after goods low", en_v1p05, 1);
      chk("R2 deep-well good with 1.05V", deep_well_ok, 1);
      pg_v1p05 = 1; sleep_aux_n = 1;
      cyc(wait_cyc(AUX_MS, 10));
      chk("R2 soft-off reached deep-well good", deep_well_ok, 1);
      chk("R2 soft-off memory still off", en_v1p8, 0);
   endtask

   task automatic to_suspend();
      pg_v1p8 = 1; pg_v1p2 = 1; sleep_soft_n = 1;
      cyc(8);
   endtask

   task automatic to_on();
      sleep_ram_n = 1;
      cyc(wait_cyc(RES_MS + POK_MS, 25));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int i_sys, i_chip, i_dw, i_core;
      void'($urandom(32'h5eed_1234));
      cyc(3);
      // R1 reset state
      chk("R1 dw3v3 in reset", en_dw3v3, 0);
      rst_n = 1;
      cyc(1);
      chk("R1 5V after reset", en_5v0, 0);
      chk("R1 deep-well good after reset", deep_well_ok, 0);
      chk("R1 pwr ok after reset", {chip_pwr_ok, sys_pwr_ok, cpu_throttle}, 0);
      chk("R1 resets and touchpad", {lightbar_rst_n, touchscreen_rst_n, touchpad_en}, 0);
      chk("R1 radio off", radio_state, radio_code("off"));

      // R2/R3: 5V goods never fall
      pg_v1p05 = 1; pg_v1p2 = 1;
      power_req = 1; cyc(2); power_req = 0;
      cyc(3);
      chk("R2 deep-well 3.3V first", en_dw3v3, 1);
      chk("R2 5V waits for settle", en_5v0, 0);
      cyc(wait_cyc(DW_MS, 3));
      chk("R2 5V after settle", en_5v0, 1);
      chk("R2 gated waits for goods low", en_dw_gated, 0);
      cyc(wait_cyc(V5_MS, 10));
      chk("R3 5V off after timeout", en_5v0, 0);
      chk("R3 deep-well good low", deep_well_ok, 0);
      chk("R3 gated never on", en_dw_gated, 0);

      // R4: 1.05V never good
      pg_v1p05 = 0; pg_v1p2 = 0;
      power_req = 1; cyc(2); power_req = 0;
      cyc(wait_cyc(DW_MS, 8));
      chk("R2 gated with deep-well good", {en_dw_gated, deep_well_ok, en_v1p05}, 7);
      cyc(wait_cyc(PG_MS, 10));
      chk("R4 rails off after 1.05V timeout", {en_v1p05, en_dw_gated, en_5v0}, 0);
      chk("R4 deep-well good low", deep_well_ok, 0);

      // pass 1: full bring-up
      bring_up();
      to_suspend();
      chk("R5 memory rails on", {en_v1p8, en_v1p2}, 3);
      chk("R5 lightbar touchpad usb", {lightbar_rst_n, touchpad_en, en_usb_5v0}, 7);
      chk("R5 still below on", chip_pwr_ok, 0);

      // R8 resume timing
      sleep_ram_n = 1;
      cyc(5);
      chk("R8 radio before resume delay", radio_state, radio_code("off"));
      cyc(23);
      chk("R8 radio on after delay", radio_state, radio_code("on"));
      chk("R8 touchscreen released", touchscreen_rst_n, 1);
      chk("R8 chip good waits settle", chip_pwr_ok, 0);
      cyc(36);
      chk("R8 chip good", chip_pwr_ok, 1);
      chk("R8 system good", sys_pwr_ok, 1);
      chk("R13 memory enabled in on", {en_v1p8, en_v1p2, en_v1p05}, 7);

      // R10 random throttle in on
      for (int k = 0; k < 10; k++) begin
         throttle_req = 1'($urandom % 2);
         cyc(5);
         chk("R10 throttle follows in on", cpu_throttle, throttle_req);
      end
      throttle_req = 1; cyc(5);

      // R9 down via suspend line
      sleep_ram_n = 0;
      i_sys = -1; i_chip = -1;
      for (int k = 0; k < 20; k++) begin
         cyc(1);
         if (i_sys < 0 && !sys_pwr_ok) i_sys = k;
         if (i_chip < 0 && !chip_pwr_ok) i_chip = k;
      end
      chk("R9 chip good falls one cycle after system", i_chip - i_sys, 1);
      cyc(GAP + 8);
      chk("R9 radio suspend", radio_state, radio_code("suspend"));
      chk("R9 throttle cleared", cpu_throttle, 0);
      chk("R9 memory kept", en_v1p8, 1);
      for (int k = 0; k < 6; k++) begin
         throttle_req = 1'($urandom % 2);
         cyc(5);
         chk("R10 throttle ignored in suspend", cpu_throttle, 0);
      end

      // R11 with pause
      pause_soft_off = 1; cyc(3);
      sleep_soft_n = 0;
      cyc(8);
      chk("R11 memory off", {en_v1p8, en_v1p2}, 0);
      chk("R11 usb touchpad off", {en_usb_5v0, touchpad_en}, 0);
      chk("R11 resets applied", {touchscreen_rst_n, lightbar_rst_n}, 0);
      chk("R11 radio off", radio_state, radio_code("off"));
      chk("R11 pause keeps deep-well good", deep_well_ok, 1);
      chk("R11 pause keeps 5V", en_5v0, 1);

      // R11 without pause
      sleep_soft_n = 1; cyc(8);
      chk("R5 usb back in suspend", en_usb_5v0, 1);
      pause_soft_off = 0; sleep_soft_n = 0;
      i_dw = -1; i_core = -1;
      for (int k = 0; k < 12; k++) begin
         cyc(1);
         if (i_dw < 0 && !deep_well_ok) i_dw = k;
         if (i_core < 0 && !en_v1p05) i_core = k;
      end
      chk("R11 deep-well good one cycle before rails", i_core - i_dw, 1);
      chk("R11 all rails off", {en_5v0, en_dw3v3, en_dw_gated}, 0);

      // pass 2: memory timeout then priority
      bring_up();
      sleep_soft_n = 1; cyc(6);
      chk("R6 memory enables on", {en_v1p8, en_v1p2}, 3);
      sleep_soft_n = 0;
      cyc(wait_cyc(PG_MS, 10));
      chk("R6 memory off after timeout", {en_v1p8, en_v1p2}, 0);
      chk("R6 deep-well good low", deep_well_ok, 0);
      chk("R6 stays soft-off", en_5v0, 1);
      to_suspend();
      chk("R5 suspend reached", en_usb_5v0, 1);
      pg_v1p8 = 0; sleep_ram_n = 1;
      i_sys = 0;
      for (int k = 0; k < 15; k++) begin
         cyc(1);
         if (radio_state == 2'(radio_code("on"))) i_sys = 1;
      end
      chk("R7 radio never on", i_sys, 0);
      chk("R7 went down", {en_v1p8, en_5v0, chip_pwr_ok}, 0);

      // pass 3: lose 1.05V in on
      bring_up();
      to_suspend();
      to_on();
      chk("R8 on reached", sys_pwr_ok, 1);
      pg_v1p05 = 0;
      cyc(6);
      chk("R9 deep-well good dropped", deep_well_ok, 0);
      chk("R9 system good dropped", sys_pwr_ok, 0);
      cyc(GAP + 8);
      chk("R9 chip good dropped", chip_pwr_ok, 0);
      chk("R12 radio suspend code", radio_state, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule